// File: doc/BRIEF.md
# Burst Column Address Generator

This block supplies the column address for every beat of a memory burst inside a 512-column row. A burst begins when `start` is pulsed. At that moment the block captures a starting column, a burst-length code and an ordering selector. From then on, each `advance` pulse moves the output to the column of the next beat. On the final beat of a fixed-length burst the block raises `last`.

Every beat of a fixed-length burst stays inside an aligned block whose size equals the burst length. The low column bits wrap inside that block, using either sequential or interleaved ordering. A full-page burst steps through the whole row and wraps from column 511 back to 0. It runs until `terminate` is asserted. Illegal settings raise `cfg_err`, and the burst then runs as a single beat.

The control is a three-state machine:
- `ST_IDLE` means no burst is running.
- `ST_FIXED` runs a burst of 1, 2, 4 or 8 beats.
- `ST_PAGE` runs an open-ended full-page burst.

The transitions are:
- From any state, `start` goes to `ST_PAGE` for a legal full-page request and to `ST_FIXED` for everything else.
- `ST_FIXED` returns to `ST_IDLE` on `terminate`, or on `advance` while `last` is high.
- `ST_PAGE` returns to `ST_IDLE` only on `terminate`.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is active, `busy`, `last` and `cfg_err` are 0 and `col_out` is 0.
- R2: A `start` pulse at a clock edge makes `busy`=1 and `col_out`=`start_col` after that edge. This holds even if a burst was already running, which is then abandoned.
- R3: `len_code` selects the burst: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. `burst_type` 0 selects sequential ordering and 1 selects interleaved. A length-1 burst has `last`=1 on its first beat.
- R4: In sequential ordering, beat n has low bits equal to (start low bits + n) mod length. The column bits above the block stay those of `start_col`.
- R5: In interleaved ordering, beat n has low bits equal to (start low bits XOR n). The column bits above the block stay those of `start_col`.
- R6: `last` is 1 exactly on the final beat of a fixed-length burst. An `advance` on that beat ends the burst: `busy`=0 and `last`=0, and `col_out` holds its value.
- R7: In a full-page burst, each `advance` adds 1 to `col_out` modulo 512, so 511 is followed by 0. `last` stays 0 throughout.
- R8: `terminate` during a burst ends it at the next edge (`busy`=0, `last`=0). It takes priority over `advance`.
- R9: Codes 4, 5 and 6, or code 7 with `burst_type`=1, set `cfg_err`=1 and run the burst as length 1. `cfg_err` keeps its value until the next `start`.
- R10: `advance` while idle, or no `advance` during a burst, changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new burst |
| start_col | input | 9 | Starting column |
| len_code | input | 3 | Burst-length code |
| burst_type | input | 1 | 0 sequential, 1 interleaved |
| advance | input | 1 | Step to the next beat |
| terminate | input | 1 | Stop the running burst |
| col_out | output | 9 | Column of the current beat |
| busy | output | 1 | Burst in progress |
| last | output | 1 | Current beat is the final beat |
| cfg_err | output | 1 | Illegal length/type combination captured |

## Verification
The bench compares the block against a behavioural model across several start patterns:
- A length-4 sequential burst starting in the middle of its block shows the wrap inside the aligned block.
- An 8-beat interleaved burst starting at an odd offset separates XOR ordering from addition.
- A length-2 burst starting at column 511 confirms that the upper bits never carry.
- A full-page burst started near 511 exercises the page wrap and confirms that `last` stays low.
- Reserved codes, aborts by a new `start`, and `terminate` racing `advance` cover the control corners.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;

    localparam logic [2:0] LEN_ONE   = 3'd0;
    localparam logic [2:0] LEN_TWO   = 3'd1;
    localparam logic [2:0] LEN_FOUR  = 3'd2;
    localparam logic [2:0] LEN_EIGHT = 3'd3;
    localparam logic [2:0] LEN_PAGE  = 3'd7;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
    parameter int COL_W  = 9,
    parameter int BEAT_W = 3
) (
    input  logic [2:0]       len_code,
    input  logic             itl,
    output logic [COL_W-1:0] blk_mask,
    output logic             full_page,
    output logic             bad_cfg
);
    import bcg_pkg::*;

    logic [BEAT_W-1:0] low_mask;

    always_comb begin
        low_mask  = '0;
        full_page = 1'b0;
        bad_cfg   = 1'b0;
        unique case (len_code)
            LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EIGHT:
                low_mask = BEAT_W'((1 << len_code[1:0]) - 1);
            LEN_PAGE: begin
                if (itl) bad_cfg   = 1'b1;
                else     full_page = 1'b1;
            end
            default: bad_cfg = 1'b1;
        endcase
        blk_mask = {{(COL_W-BEAT_W){1'b0}}, low_mask};
    end
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
    parameter int COL_W  = 9,
    parameter int BEAT_W = 3
) (
    input  logic [COL_W-1:0]  base,
    input  logic [BEAT_W-1:0] beat,
    input  logic [COL_W-1:0]  blk_mask,
    input  logic              itl,
    output logic [COL_W-1:0]  col
);
    logic [COL_W-1:0] beat_ext;
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] itl_low;

    always_comb begin
        beat_ext = {{(COL_W-BEAT_W){1'b0}}, beat};
        seq_low  = (base + beat_ext) & blk_mask;
        itl_low  = (base ^ beat_ext) & blk_mask;
        col      = (base & ~blk_mask) | (itl ? itl_low : seq_low);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W   = 9,
    parameter int MAX_LEN = 8,
    localparam int BEAT_W = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             burst_type,
    input  logic             advance,
    input  logic             terminate,
    output logic [COL_W-1:0] col_out,
    output logic             busy,
    output logic             last,
    output logic             cfg_err
);
    import bcg_pkg::*;

    bcg_state_e        state_q, state_d;
    logic [COL_W-1:0]  base_q, mask_q, col_q;
    logic              itl_q, last_q, err_q;
    logic [BEAT_W-1:0] beat_q, beat_nxt;
    logic [COL_W-1:0]  dec_mask, col_step;
    logic              dec_page, dec_err;

    bcg_len_decode #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_dec (
        .len_code (len_code),
        .itl      (burst_type),
        .blk_mask (dec_mask),
        .full_page(dec_page),
        .bad_cfg  (dec_err)
    );

    assign beat_nxt = beat_q + 1'b1;

    bcg_addr_calc #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_calc (
        .base    (base_q),
        .beat    (beat_nxt),
        .blk_mask(mask_q),
        .itl     (itl_q),
        .col     (col_step)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = dec_page ? ST_PAGE : ST_FIXED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FIXED: if (terminate || (advance && last_q)) state_d = ST_IDLE;
                ST_PAGE:  if (terminate) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // beat and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            itl_q  <= 1'b0;
            beat_q <= '0;
            col_q  <= '0;
            last_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (start) begin
            base_q <= start_col;
            mask_q <= dec_mask;
            itl_q  <= burst_type;
            beat_q <= '0;
            col_q  <= start_col;
            last_q <= !dec_page && (dec_mask[BEAT_W-1:0] == '0);
            err_q  <= dec_err;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_FIXED: begin
                    if (terminate || (advance && last_q)) begin
                        last_q <= 1'b0;
                    end else if (advance) begin
                        beat_q <= beat_nxt;
                        col_q  <= col_step;
                        last_q <= (beat_nxt == mask_q[BEAT_W-1:0]);
                    end
                end
                ST_PAGE: begin
                    if (advance && !terminate) col_q <= col_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign col_out = col_q;
    assign busy    = (state_q != ST_IDLE);
    assign last    = last_q;
    assign cfg_err = err_q;
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic [2:0]       len_code,
    input logic             burst_type,
    input logic             advance,
    input logic             terminate,
    input logic [COL_W-1:0] col_out,
    input logic             busy,
    input logic             last,
    input logic             cfg_err
);
    logic             pg_q;
    logic [COL_W-1:0] blk_q;
    logic             bad_req;

    assign bad_req = (len_code == 3'd4) || (len_code == 3'd5) || (len_code == 3'd6) ||
                     ((len_code == 3'd7) && burst_type);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q  <= 1'b0;
            blk_q <= '0;
        end else if (start) begin
            pg_q  <= (len_code == 3'd7) && !burst_type;
            blk_q <= bad_req ? '0 : COL_W'((1 << len_code[1:0]) - 1);
        end
    end

    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && (col_out == $past(start_col)));

    assert_last_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> busy);

    assert_in_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !pg_q && !start |=> ((col_out & ~blk_q) == ($past(col_out) & ~blk_q)));

    assert_page_nolast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && pg_q |-> !last);

    assert_page_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && pg_q && advance && !terminate && !start |=>
            (col_out == COL_W'($past(col_out) + 1'b1)));

    assert_terminate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && terminate && !start |=> !busy);

    assert_bad_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start && bad_req |=> cfg_err && last);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .len_code  (len_code),
    .burst_type(burst_type),
    .advance   (advance),
    .terminate (terminate),
    .col_out   (col_out),
    .busy      (busy),
    .last      (last),
    .cfg_err   (cfg_err)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       burst_type = 1'b0;
    logic       advance = 1'b0;
    logic       terminate = 1'b0;
    logic [8:0] col_out;
    logic       busy, last, cfg_err;

    int n_checks = 0;
    int n_fail   = 0;

    // packed expectation: {busy, last, err, col}
    logic [11:0] exp_q[$];
    string       tag_q[$];

    // behavioural model state
    bit m_busy = 0, m_page = 0, m_itl = 0, m_last = 0, m_err = 0;
    int m_len = 1, m_base = 0, m_beat = 0, m_col = 0;

    burst_col_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len_code(len_code), .burst_type(burst_type), .advance(advance),
        .terminate(terminate), .col_out(col_out), .busy(busy),
        .last(last), .cfg_err(cfg_err)
    );

    always #4 clk = ~clk;

    task automatic model(input bit s, input int sc, input int lc, input bit bt,
                         input bit adv, input bit trm);
        int off;
        if (s) begin
            m_err = 0; m_page = 0; m_len = 1;
            case (lc)
                0: m_len = 1;
                1: m_len = 2;
                2: m_len = 4;
                3: m_len = 8;
                7: if (bt) m_err = 1; else m_page = 1;
                default: m_err = 1;
            endcase
            m_itl = bt; m_base = sc; m_beat = 0; m_col = sc; m_busy = 1;
            m_last = !m_page && (m_len == 1);
        end else if (m_busy && trm) begin
            m_busy = 0; m_last = 0;
        end else if (m_busy && adv) begin
            if (m_page) begin
                m_col = (m_col + 1) % 512;
            end else if (m_last) begin
                m_busy = 0; m_last = 0;
            end else begin
                m_beat++;
                if (m_itl) off = (m_base % m_len) ^ m_beat;
                else       off = ((m_base % m_len) + m_beat) % m_len;
                m_col  = m_base - (m_base % m_len) + off;
                m_last = (m_beat == m_len - 1);
            end
        end
    endtask

    // driver: one call per clock, pushes the expectation for the following edge
    task automatic step(input bit s, input int sc, input int lc, input bit bt,
                        input bit adv, input bit trm, input string tag);
        @(negedge clk);
        start = s; start_col = 9'(sc); len_code = 3'(lc); burst_type = bt;
        advance = adv; terminate = trm;
        model(s, sc, lc, bt, adv, trm);
        exp_q.push_back({m_busy, m_last, m_err, 9'(m_col)});
        tag_q.push_back(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [11:0] e, g;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                g = {busy, last, cfg_err, col_out};
                n_checks++;
                if (g !== e) begin
                    n_fail++;
                    $display("FAIL %s: got busy=%0b last=%0b err=%0b col=%0d, expected busy=%0b last=%0b err=%0b col=%0d",
                             t, g[11], g[10], g[9], g[8:0], e[11], e[10], e[9], e[8:0]);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(8 * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if ({busy, last, cfg_err, col_out} !== 12'd0) begin
            n_fail++;
            $display("FAIL R1: got busy=%0b last=%0b err=%0b col=%0d, expected all 0",
                     busy, last, cfg_err, col_out);
        end
        @(negedge clk); rst_n = 1'b1;

        step(0, 0, 0, 0, 1, 0, "R10 advance idle");
        // sequential len 4 from 13: 13,14,15,12
        step(1, 13, 2, 0, 0, 0, "R2 load");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, "R4 seq wrap");
        step(0, 0, 0, 0, 1, 0, "R6 end on last");
        step(0, 0, 0, 0, 1, 0, "R10 idle hold");
        // interleaved len 8 from 29
        step(1, 29, 3, 1, 0, 0, "R3 len8 itl");
        for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 1, 0, "R5 interleave");
        step(0, 0, 0, 0, 1, 0, "R6 end itl");
        // len 2 at top of row
        step(1, 511, 1, 0, 0, 0, "R3 len2");
        step(0, 0, 0, 0, 1, 0, "R4 len2 wrap");
        step(0, 0, 0, 0, 0, 0, "R10 no advance");
        step(0, 0, 0, 0, 1, 0, "R6 len2 end");
        // len 1
        step(1, 100, 0, 0, 0, 0, "R3 len1 last");
        step(0, 0, 0, 0, 1, 0, "R6 len1 end");
        // full page
        step(1, 509, 7, 0, 0, 0, "R7 page start");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, "R7 page wrap");
        step(0, 0, 0, 0, 0, 0, "R10 page hold");
        step(0, 0, 0, 0, 1, 1, "R8 terminate beats advance");
        // error cases
        step(1, 40, 5, 0, 0, 0, "R9 reserved code");
        step(0, 0, 0, 0, 1, 0, "R9 err as len1");
        step(0, 0, 0, 0, 0, 0, "R9 err held");
        step(1, 40, 7, 1, 0, 0, "R9 page itl");
        step(1, 8, 1, 0, 0, 0, "R9 err cleared");
        // abort and terminate in fixed burst
        step(1, 3, 3, 0, 0, 0, "R2 len8 start");
        step(0, 0, 0, 0, 1, 0, "R4 seq step");
        step(1, 20, 2, 1, 0, 0, "R2 abort restart");
        step(0, 0, 0, 0, 1, 0, "R5 itl step");
        step(0, 0, 0, 0, 0, 1, "R8 terminate fixed");
        step(0, 0, 0, 0, 1, 0, "R10 idle after terminate");
        step(0, 0, 0, 0, 0, 0, "R10 idle");
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule